// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer Engine

This block sits behind a two-wire bus protocol front end inside a serial EEPROM model or controller. The front end has already decoded the device address and the two word-address bytes. It tells this block when a write transaction opens, passing the starting word address. It then hands over each received data byte and reports when it sees the STOP condition. The block gathers the bytes into a 32-byte page buffer. The low five address bits step through the page and wrap from the last slot back to the first. The upper address bits stay fixed for the whole transaction.

When STOP arrives after at least one byte, the block enters a self-timed programming window. Its length is a parameter given in clock cycles, so the same RTL can model the 5 ms or the 10 ms grade at any clock rate. During the window the block drives a byte-wide write port towards the array. It writes each buffered slot once, in ascending slot order. While the window runs the block raises a busy flag and ignores every transaction input. The front end uses the busy flag to withhold its acknowledge during polling. A write-protect input, sampled at STOP, turns the whole window into a no-op when the page lies in the upper half of the array.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy and memWe are both low.
- R2: A data byte is stored at the page slot given by the current low five address bits, starting from the low five bits of loadAddr. After each accepted byte, only those five bits increment, wrapping from slot 31 to slot 0. The bits above them keep the value taken from loadAddr.
- R3: When more than 32 bytes arrive before STOP, later bytes overwrite the earlier bytes at the same slot, and only the last value per slot is written to the array.
- R4: No array write happens before STOP. When stopSeen is accepted with at least one buffered byte, busy rises on the next cycle and stays high for exactly WRITE_CYCLES cycles.
- R5: During the window, each slot that received a byte is written exactly once, in ascending slot order. The address is {upper address bits, slot} and the data is the slot's byte. Slots that received no byte in this transaction are not written.
- R6: A STOP with no data byte received since loadStart starts no window: busy stays low and no write occurs.
- R7: While busy is high, loadStart, byteValid and stopSeen have no effect. Bytes offered then are never written, and a STOP after the window, without a fresh loadStart, starts nothing.
- R8: If wpIn is high when STOP is accepted and the page lies in the upper half of the array (address MSB = 1), no write occurs, but busy still runs for the full WRITE_CYCLES.
- R9: wpIn high does not block a page in the lower half (address MSB = 0).
- R10: memWe is asserted only while busy is high.
- R11: byteValid with no transaction open (no loadStart since the last STOP or window) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStart | input | 1 | Opens a write transaction (one-cycle strobe) |
| loadAddr | input | ADDR_W | Starting word address, captured with loadStart |
| byteValid | input | 1 | Data byte strobe |
| byteData | input | 8 | Data byte |
| stopSeen | input | 1 | STOP condition strobe from the front end |
| wpIn | input | 1 | Write protect for the upper half of the array |
| busy | output | 1 | Programming window in progress |
| memWe | output | 1 | Array byte write enable |
| memAddr | output | ADDR_W | Array byte address |
| memData | output | 8 | Array byte data |

## Verification
The main function is driven with a vector table of transactions:
- A single byte, which shows one-slot commits.
- A short run crossing slot 31, which separates an in-page wrap from a carry into the upper bits.
- A full page, which shows all 32 slots written.
- A 35-byte run, which shows that the last value per slot wins.
- A protected upper-half page against the same page unprotected, which separates the protect decision from the timer.
- A lower-half page with protect high, which shows that protect does not reach below the midpoint.

For each transaction the bench checks three things: that no write occurs before STOP, the exact busy length, and the exact ordered list of array writes.

Directed tests cover inputs offered during the window, an empty STOP, and a stray byte outside any transaction.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // strobes from the control FSM to the page datapath
  typedef struct packed {
    logic load;     // open transaction: capture address, clear mask
    logic accept;   // store one byte at the current slot
    logic clearAll; // end of window: drop the valid mask
  } pwbStrobe_t;
endpackage

// File: rtl/pwb_data.sv
module pwb_data
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwbStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    loadAddr,
  input  logic [7:0]           byteData,
  input  logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic                 anyValid,
  output logic                 slotValid,
  output logic [7:0]           slotData,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageBase
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - SLOT_W;

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [SLOT_W-1:0]     slotPtr;
  logic [BASE_W-1:0]     baseReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      slotPtr   <= '0;
      baseReg   <= '0;
    end else if (strobe.load) begin
      baseReg   <= loadAddr[ADDR_W-1:SLOT_W];
      slotPtr   <= loadAddr[SLOT_W-1:0];
      validMask <= '0;
    end else if (strobe.accept) begin
      validMask[slotPtr] <= 1'b1;
      slotPtr            <= slotPtr + 1'b1; // wraps inside the page
    end else if (strobe.clearAll) begin
      validMask <= '0;
    end
  end

  generate
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strobe.accept && !strobe.load && slotPtr == SLOT_W'(s))
          pageBuf[s] <= byteData;
      end
    end
  endgenerate

  assign anyValid  = |validMask;
  assign slotValid = validMask[scanIdx];
  assign slotData  = pageBuf[scanIdx];
  assign pageBase  = baseReg;
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStart,
  input  logic       byteValid,
  input  logic       stopSeen,
  input  logic       wpIn,
  input  logic       anyValid,
  input  logic       slotValid,
  input  logic       pageTop,
  output pwbStrobe_t strobe,
  output logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic       busy,
  output logic       writeEn
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int TMR_W  = $clog2(WRITE_CYCLES + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(PAGE_BYTES - 1);
  localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_PROG} pwbState_t;

  pwbState_t         state;
  logic [TMR_W-1:0]  timer;
  logic              scanDone;
  logic              guard;

  always_comb begin
    strobe.load     = (state != ST_PROG) && loadStart;
    strobe.accept   = (state == ST_FILL) && byteValid && !loadStart && !stopSeen;
    strobe.clearAll = (state == ST_PROG) && (timer == TMR_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      scanIdx  <= '0;
      scanDone <= 1'b1;
      guard    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (loadStart) state <= ST_FILL;
        ST_FILL: begin
          if (loadStart) begin
            state <= ST_FILL;
          end else if (stopSeen) begin
            state    <= anyValid ? ST_PROG : ST_IDLE;
            guard    <= wpIn && pageTop;
            timer    <= '0;
            scanIdx  <= '0;
            scanDone <= 1'b0;
          end
        end
        ST_PROG: begin
          timer <= timer + 1'b1;
          if (!scanDone) begin
            scanIdx <= scanIdx + 1'b1;
            if (scanIdx == SLOT_LAST) scanDone <= 1'b1;
          end
          if (timer == TMR_LAST) begin
            state    <= ST_IDLE;
            scanDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state == ST_PROG);
  assign writeEn = busy && !scanDone && slotValid && !guard;
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pwb_pkg::*;
#(
  parameter int MEM_DEPTH    = 4096,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         loadStart,
  input  logic [$clog2(MEM_DEPTH)-1:0] loadAddr,
  input  logic                         byteValid,
  input  logic [7:0]                   byteData,
  input  logic                         stopSeen,
  input  logic                         wpIn,
  output logic                         busy,
  output logic                         memWe,
  output logic [$clog2(MEM_DEPTH)-1:0] memAddr,
  output logic [7:0]                   memData
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - SLOT_W;

  pwbStrobe_t        strobe;
  logic [SLOT_W-1:0] scanIdx;
  logic              anyValid;
  logic              slotValid;
  logic [7:0]        slotData;
  logic [BASE_W-1:0] pageBase;

  pwb_ctrl #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadStart(loadStart),
    .byteValid(byteValid),
    .stopSeen (stopSeen),
    .wpIn     (wpIn),
    .anyValid (anyValid),
    .slotValid(slotValid),
    .pageTop  (pageBase[BASE_W-1]),
    .strobe   (strobe),
    .scanIdx  (scanIdx),
    .busy     (busy),
    .writeEn  (memWe)
  );

  pwb_data #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadAddr (loadAddr),
    .byteData (byteData),
    .scanIdx  (scanIdx),
    .anyValid (anyValid),
    .slotValid(slotValid),
    .slotData (slotData),
    .pageBase (pageBase)
  );

  assign memAddr = {pageBase, scanIdx};
  assign memData = slotData;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int MEM_DEPTH    = 4096,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 625000
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         stopSeen,
  input logic                         busy,
  input logic                         memWe,
  input logic [$clog2(MEM_DEPTH)-1:0] memAddr
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int SLOT_W = $clog2(PAGE_BYTES);

  logic [31:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 32'd1 : 32'd0;
  end

  // R10
  we_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R4
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == 32'(WRITE_CYCLES));

  // R5
  slot_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr[SLOT_W-1:0] > $past(memAddr[SLOT_W-1:0]));

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr[ADDR_W-1:SLOT_W] == $past(memAddr[ADDR_W-1:SLOT_W]));
endmodule

bind eeprom_page_writer pwb_checker #(
  .MEM_DEPTH   (MEM_DEPTH),
  .PAGE_BYTES  (PAGE_BYTES),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_pwbChk (
  .clk     (clk),
  .rstN    (rstN),
  .stopSeen(stopSeen),
  .busy    (busy),
  .memWe   (memWe),
  .memAddr (memAddr)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;
  localparam int MEM_DEPTH = 4096;
  localparam int PAGE      = 32;
  localparam int WCYC      = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStart = 1'b0;
  logic [11:0] loadAddr = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        stopSeen = 1'b0;
  logic        wpIn = 1'b0;
  logic        busy, memWe;
  logic [11:0] memAddr;
  logic [7:0]  memData;

  always #4 clk = ~clk;

  eeprom_page_writer #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .loadAddr(loadAddr),
    .byteValid(byteValid), .byteData(byteData), .stopSeen(stopSeen), .wpIn(wpIn),
    .busy(busy), .memWe(memWe), .memAddr(memAddr), .memData(memData));

  int testsRun = 0;
  int testsFailed = 0;

  // write monitor: log every array write seen between clock edges
  logic [11:0] logA [256];
  logic [7:0]  logD [256];
  int totN = 0;
  always @(negedge clk) begin
    if (memWe && totN < 256) begin
      logA[totN] = memAddr;
      logD[totN] = memData;
      totN = totN + 1;
    end
  end

  typedef struct packed {
    logic [11:0] addr;
    logic [7:0]  count;
    logic        wp;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{12'h010, 8'd1,  1'b0, 8'h11},  // single byte
    '{12'h01E, 8'd4,  1'b0, 8'h20},  // wraps 31 -> 0 inside page
    '{12'h105, 8'd32, 1'b0, 8'h40},  // full page
    '{12'h203, 8'd35, 1'b0, 8'h80},  // overwrite of slots 3..5
    '{12'h805, 8'd3,  1'b1, 8'hA0},  // upper half, protected
    '{12'h805, 8'd3,  1'b0, 8'hB0},  // upper half, unprotected
    '{12'h7FF, 8'd2,  1'b1, 8'hC0}   // lower half with protect high
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic pulseLoad(input logic [11:0] a);
    loadStart = 1'b1; loadAddr = a;
    @(negedge clk);
    loadStart = 1'b0;
  endtask

  task automatic pulseByte(input logic [7:0] d);
    byteValid = 1'b1; byteData = d;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic pulseStop();
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    logic [7:0] expBuf [PAGE];
    bit         expVal [PAGE];
    logic [4:0] slot;
    int startN, nExp, cyc, idx;
    bit ok;
    for (int i = 0; i < PAGE; i++) begin expVal[i] = 0; expBuf[i] = '0; end
    slot = v.addr[4:0];
    for (int i = 0; i < int'(v.count); i++) begin
      expBuf[slot] = v.seed + 8'(i);
      expVal[slot] = 1;
      slot = slot + 5'd1;
    end
    startN = totN;
    pulseLoad(v.addr);
    for (int i = 0; i < int'(v.count); i++) pulseByte(v.seed + 8'(i));
    wpIn = v.wp;
    check(totN == startN && !busy, "R4", "write or busy before STOP", totN - startN, 0);
    pulseStop();
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
    wpIn = 1'b0;
    check(cyc == WCYC, (v.wp && v.addr[11]) ? "R8" : "R4", "busy cycles", cyc, WCYC);
    // expected write list, ascending slots
    ok = 1; idx = startN; nExp = 0;
    if (!(v.wp && v.addr[11])) begin
      for (int s = 0; s < PAGE; s++) begin
        if (expVal[s]) begin
          nExp++;
          if (idx >= totN) ok = 0;
          else if (logA[idx] != {v.addr[11:5], 5'(s)} || logD[idx] != expBuf[s]) begin
            ok = 0;
            $display("FAIL R5 write %0d at slot %0d: actual %0h/%0h expected %0h/%0h",
                     idx - startN, s, logA[idx], logD[idx], {v.addr[11:5], 5'(s)}, expBuf[s]);
          end
          idx++;
        end
      end
    end
    if (totN - startN != nExp) ok = 0;
    // R2 R3 R5 R8 R9: exact write list per vector
    check(ok, (v.wp && v.addr[11]) ? "R8" : (v.count > 32 ? "R3" : (v.wp ? "R9" : "R5")),
          "write list count", totN - startN, nExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int startN, cyc;
    bit sawBusy;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(memWe == 1'b0, "R1", "memWe in reset", memWe, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && memWe == 1'b0, "R1", "idle after reset", {busy, memWe}, 0);

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R7 inputs during the window are ignored
    startN = totN;
    pulseLoad(12'h040);
    pulseByte(8'h5A);
    pulseByte(8'h5B);
    pulseStop();
    pulseLoad(12'h300);
    pulseByte(8'hEE);
    pulseByte(8'hEF);
    pulseStop();
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
    check(totN - startN == 2 && logA[startN] == 12'h040 && logD[startN] == 8'h5A
          && logA[startN+1] == 12'h041 && logD[startN+1] == 8'h5B,
          "R7", "writes with inputs during busy", totN - startN, 2);
    pulseStop();
    sawBusy = 0;
    repeat (5) begin sawBusy |= busy; @(negedge clk); end
    check(!sawBusy && totN - startN == 2, "R7", "stop after window without load", sawBusy, 0);

    // R11 stray byte outside any transaction, then STOP
    startN = totN;
    pulseByte(8'h99);
    pulseStop();
    sawBusy = 0;
    repeat (5) begin sawBusy |= busy; @(negedge clk); end
    check(!sawBusy && totN == startN, "R11", "stray byte started a window", sawBusy, 0);

    // R6 empty transaction
    pulseLoad(12'h060);
    pulseStop();
    sawBusy = 0;
    repeat (5) begin sawBusy |= busy; @(negedge clk); end
    check(!sawBusy, "R6", "busy on empty STOP", sawBusy, 0);
    check(totN == startN, "R6", "writes on empty STOP", totN - startN, 0);

    // R10 no write outside the window
    check(memWe == 1'b0 && busy == 1'b0, "R10", "memWe while idle", memWe, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule